// File: doc/BRIEF.md
# Masked Minimum-Width Pulse Qualifier

This block sits between the raw discriminator inputs of a detector front end and the trigger-forming logic. It serves two channel groups: scintillator channels (53 by default) and neutron-detector channels (16 by default). Every channel is first passed through a two-flop synchronizer. It then feeds a saturating run-length counter that counts consecutive high samples and clears on the first low sample. A channel's qualified output is asserted only when the channel's enable bit is set and its run length has reached the minimum width programmed for its group. The output then stays high until the input drops.

Each group has its own 16-bit minimum-width setting, counted in clock periods. Both settings reset to 2, and a setting of 0 or 1 acts as 1. The enable bits are arranged as 16-bit words. Each 32-channel slice has a low word and a high word. All enable bits reset to 0, so nothing passes until software enables it through the write port.

Top module: `pulse_qual_top`

## Requirements
- R1: After reset, every qualified output is low, every enable bit is 0 and both minimum-width settings are 2. Once a channel is enabled, a 1-sample pulse is rejected and a 2-sample pulse is accepted.
- R2: A channel whose enable bit is 0 never asserts its qualified output, whatever its input does.
- R3: A pulse that is sampled fewer times than its group's effective minimum width T never asserts the output.
- R4: For an enabled channel, if the raw input is first sampled high at clock edge 1, the output rises right after edge 2+T. The delay is two synchronizer edges plus T counting edges.
- R5: A pulse sampled N >= T times holds the output high for exactly N-T+1 cycles. The output falls the cycle after the counter clears on a low sample.
- R6: A minimum-width setting of 0 or 1 behaves as a width of 1, so a single high sample is accepted.
- R7: The two groups use independent widths. A pulse of the same length can be rejected in one group and accepted in the other.
- R8: The write port (wr_en, wr_addr, wr_data) uses this map. Address 0 holds the scintillator width and address 1 the neutron width. Addresses 2 and 3 enable scintillator channels 0-15 and 16-31. Addresses 4 and 5 enable scintillator channels 32-47 and 48-63. Addresses 6 and 7 enable neutron channels 0-15 and 16-31. Bit i of an enable word maps to channel (word base + i). A write to one half leaves the other half unchanged. Writes to addresses 8-15 change nothing.
- R9: The run-length counter saturates instead of wrapping. With a width of 65535, a 65536-sample pulse gives exactly 2 high output cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one width unit per period |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| sci_raw | input | 53 | Raw scintillator discriminator inputs |
| neu_raw | input | 16 | Raw neutron-detector discriminator inputs |
| sci_qual | output | 53 | Qualified scintillator channels |
| neu_qual | output | 16 | Qualified neutron-detector channels |

## Verification
Each channel's internal state reaches the ports directly. A wrong run-length count moves the rising edge of that channel's qualified output away from edge 2+T, or changes its high-cycle count away from N-T+1. Either error shows up within the pulse that caused it. A wrong enable bit or width setting appears on the very next pulse of the affected channel or group. The bench also watches every channel it did not pulse, so a crossed enable bit or group shows up as stray activity on the same pulse.

// File: rtl/pq_pkg.sv
package pq_pkg;
  localparam int DW = 16;

  // Effective threshold: settings below 2 collapse to 1.
  function automatic logic [DW-1:0] eff_thr(input logic [DW-1:0] w);
    return (w < DW'(2)) ? DW'(1) : w;
  endfunction

  // Increment that sticks at the all-ones value.
  function automatic logic [DW-1:0] sat_inc(input logic [DW-1:0] v);
    return (v == '1) ? v : v + DW'(1);
  endfunction
endpackage

// File: rtl/pq_sync.sv
module pq_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/pq_regs.sv
module pq_regs
  import pq_pkg::*;
#(
  parameter int SCI_CH = 53,
  parameter int NEU_CH = 16,
  parameter int AW     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  output logic [SCI_CH-1:0] sci_mask,
  output logic [NEU_CH-1:0] neu_mask,
  output logic [DW-1:0]     sci_width,
  output logic [DW-1:0]     neu_width
);
  localparam int SCI_PORTS = (SCI_CH + 31) / 32;
  localparam int SCI_BASE  = 2;
  localparam int NEU_BASE  = SCI_BASE + 2 * SCI_PORTS;
  localparam logic [DW-1:0] WIDTH_RST = DW'(2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sci_width <= WIDTH_RST;
      neu_width <= WIDTH_RST;
    end else if (wr_en) begin
      if (wr_addr == AW'(0)) sci_width <= wr_data;
      if (wr_addr == AW'(1)) neu_width <= wr_data;
    end
  end

  // Only bits of existing channels are stored; word = base + channel/16.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sci_mask <= '0;
    end else if (wr_en) begin
      for (int c = 0; c < SCI_CH; c++)
        if (wr_addr == AW'(SCI_BASE + c / 16)) sci_mask[c] <= wr_data[c % 16];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      neu_mask <= '0;
    end else if (wr_en) begin
      for (int c = 0; c < NEU_CH; c++)
        if (wr_addr == AW'(NEU_BASE + c / 16)) neu_mask[c] <= wr_data[c % 16];
    end
  end

  AST_WIDTH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == AW'(0)) |=> (sci_width == $past(wr_data))); // R8
endmodule

// File: rtl/pq_width_chan.sv
module pq_width_chan
  import pq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_i,
  input  logic          en_i,
  input  logic [DW-1:0] thr_i,
  output logic          qual_o
);
  logic [DW-1:0] cnt_q;
  logic [DW-1:0] cnt_nxt;
  logic          hit;

  assign cnt_nxt = s_i ? sat_inc(cnt_q) : '0;
  assign hit     = s_i && (cnt_nxt >= thr_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      qual_o <= 1'b0;
    end else begin
      cnt_q  <= cnt_nxt;
      qual_o <= en_i && hit;
    end
  end

  AST_MASK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    qual_o |-> $past(en_i)); // R2
  AST_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    qual_o |-> (cnt_q >= $past(thr_i))); // R3
  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(s_i) |-> (cnt_q == '0 && !qual_o)); // R5
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(s_i) |-> (cnt_q != '0)); // R9
endmodule

// File: rtl/pulse_qual_top.sv
module pulse_qual_top
  import pq_pkg::*;
#(
  parameter int SCI_CH = 53,
  parameter int NEU_CH = 16,
  parameter int AW     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [SCI_CH-1:0] sci_raw,
  input  logic [NEU_CH-1:0] neu_raw,
  output logic [SCI_CH-1:0] sci_qual,
  output logic [NEU_CH-1:0] neu_qual
);
  logic [SCI_CH-1:0] sci_mask, sci_s;
  logic [NEU_CH-1:0] neu_mask, neu_s;
  logic [DW-1:0]     sci_width, neu_width;
  logic [DW-1:0]     sci_thr, neu_thr;

  pq_regs #(.SCI_CH(SCI_CH), .NEU_CH(NEU_CH), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sci_mask(sci_mask), .neu_mask(neu_mask),
    .sci_width(sci_width), .neu_width(neu_width)
  );

  assign sci_thr = eff_thr(sci_width);
  assign neu_thr = eff_thr(neu_width);

  pq_sync #(.W(SCI_CH)) u_sync_sci (.clk(clk), .rst_n(rst_n), .d_i(sci_raw), .q_o(sci_s));
  pq_sync #(.W(NEU_CH)) u_sync_neu (.clk(clk), .rst_n(rst_n), .d_i(neu_raw), .q_o(neu_s));

  for (genvar g = 0; g < SCI_CH; g++) begin : g_sci
    pq_width_chan u_chan (
      .clk(clk), .rst_n(rst_n), .s_i(sci_s[g]), .en_i(sci_mask[g]),
      .thr_i(sci_thr), .qual_o(sci_qual[g])
    );
  end

  for (genvar g = 0; g < NEU_CH; g++) begin : g_neu
    pq_width_chan u_chan (
      .clk(clk), .rst_n(rst_n), .s_i(neu_s[g]), .en_i(neu_mask[g]),
      .thr_i(neu_thr), .qual_o(neu_qual[g])
    );
  end

  AST_THR_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (sci_thr != '0) && (neu_thr != '0)); // R6
endmodule

// File: tb/tb_pulse_qual_top.sv
module tb_pulse_qual_top;
  localparam int SCI_CH = 53;
  localparam int NEU_CH = 16;
  localparam int AW     = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [AW-1:0]     wr_addr = '0;
  logic [15:0]       wr_data = '0;
  logic [SCI_CH-1:0] sci_raw = '0;
  logic [NEU_CH-1:0] neu_raw = '0;
  logic [SCI_CH-1:0] sci_qual;
  logic [NEU_CH-1:0] neu_qual;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pulse_qual_top #(.SCI_CH(SCI_CH), .NEU_CH(NEU_CH), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sci_raw(sci_raw), .neu_raw(neu_raw),
    .sci_qual(sci_qual), .neu_qual(neu_qual)
  );

  // grp 0 = scintillator, 1 = neutron
  typedef struct packed {
    logic        grp;
    logic [7:0]  ch;
    logic [15:0] w;
    logic [16:0] len;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'd0,  16'd3, 17'd2},   // R3 short reject
    '{1'b0, 8'd0,  16'd3, 17'd3},   // R4 exact width
    '{1'b0, 8'd52, 16'd5, 17'd9},   // R5 top channel
    '{1'b1, 8'd15, 16'd4, 17'd3},   // R3 neutron reject
    '{1'b1, 8'd7,  16'd4, 17'd10},  // R5 neutron hold
    '{1'b0, 8'd17, 16'd0, 17'd1},   // R6 width 0
    '{1'b1, 8'd0,  16'd1, 17'd1},   // R6 width 1
    '{1'b0, 8'd33, 16'd2, 17'd4}    // R4 second slice
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic int thr_of(input int w);
    return (w < 2) ? 1 : w;
  endfunction

  function automatic int exp_cnt(input int len, input int t);
    return (len >= t) ? len - t + 1 : 0;
  endfunction

  // Drives the selected bits for len cycles; counts high cycles and first-high index.
  task automatic run(input logic [SCI_CH-1:0] sb, input logic [NEU_CH-1:0] nb,
                     input int len, output int sc, output int nc,
                     output int sf, output int nf, output int stray);
    sc = 0; nc = 0; sf = -1; nf = -1; stray = 0;
    for (int k = 0; k < len + 6; k++) begin
      @(negedge clk);
      if (|(sci_qual & sb)) begin sc++; if (sf < 0) sf = k; end
      if (|(neu_qual & nb)) begin nc++; if (nf < 0) nf = k; end
      if ((|(sci_qual & ~sb)) || (|(neu_qual & ~nb))) stray++;
      sci_raw = (k < len) ? sb : '0;
      neu_raw = (k < len) ? nb : '0;
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    int sc, nc, sf, nf, st;
    logic [SCI_CH-1:0] sb;
    logic [NEU_CH-1:0] nb;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(sci_qual == '0 && neu_qual == '0, "R1 outputs low", int'(|sci_qual), 0);

    // R2 disabled channel (masks reset to 0)
    run(53'(1) << 20, '0, 10, sc, nc, sf, nf, st);
    chk(sc == 0 && st == 0, "R2 masked channel", sc, 0);
    run('0, 16'(1) << 3, 10, sc, nc, sf, nf, st);
    chk(nc == 0, "R2 masked neutron", nc, 0);

    // R1 default width 2
    wr(2, 16'h0001);
    run(53'(1), '0, 1, sc, nc, sf, nf, st);
    chk(sc == 0, "R1 default width rejects 1", sc, 0);
    run(53'(1), '0, 2, sc, nc, sf, nf, st);
    chk(sc == 1 && sf == 4, "R1 default width accepts 2", sc, 1);

    // enable everything
    for (int a = 2; a < 8; a++) wr(a, 16'hFFFF);

    // table walk
    for (int v = 0; v < NV; v++) begin
      int t, e, c, f;
      wr(VECS[v].grp ? 1 : 0, int'(VECS[v].w));
      t = thr_of(int'(VECS[v].w));
      e = exp_cnt(int'(VECS[v].len), t);
      sb = '0; nb = '0;
      if (VECS[v].grp) nb[VECS[v].ch] = 1'b1; else sb[VECS[v].ch] = 1'b1;
      run(sb, nb, int'(VECS[v].len), sc, nc, sf, nf, st);
      c = VECS[v].grp ? nc : sc;
      f = VECS[v].grp ? nf : sf;
      chk(c == e, "R3/R5 table high count", c, e);
      chk(e == 0 || f == 2 + t, "R4 table rise cycle", f, 2 + t);
      chk(st == 0, "R2 table stray", st, 0);
    end

    // R7 independent group widths
    wr(0, 6); wr(1, 2);
    run(53'(1) << 5, 16'(1) << 5, 3, sc, nc, sf, nf, st);
    chk(sc == 0, "R7 scint width 6 rejects 3", sc, 0);
    chk(nc == 2, "R7 neutron width 2 accepts 3", nc, 2);

    // R8 half independence and ignored addresses
    wr(0, 2);
    wr(3, 16'h0000);
    for (int a = 8; a < 16; a++) wr(a, 16'h0000);
    run(53'(1) << 16, '0, 4, sc, nc, sf, nf, st);
    chk(sc == 0, "R8 high half cleared", sc, 0);
    run(53'(1), 16'(1) << 9, 4, sc, nc, sf, nf, st);
    chk(sc == 3, "R8 low half kept", sc, 3);
    chk(nc == 3, "R8 unused address ignored", nc, 3);

    // R9 saturation
    wr(0, 16'hFFFF);
    run(53'(1) << 1, '0, 65536, sc, nc, sf, nf, st);
    chk(sc == 2, "R9 saturating counter", sc, 2);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule